// File: doc/BRIEF.md
# Dual-Link Frame Check and Select

This block receives one data frame per acquisition period over two redundant links, a preferred link A and a backup link B. Each link delivers its frame as a burst of eight 32-bit words, which together form a 256-bit frame. The block checks each copy against its own CRC-32 and compares the CRC fields of the two copies. It then picks one copy to forward and reports which link it used and which links failed. For the forwarded copy, the block compares the source card identifier with a configured value and checks that the frame number has advanced by exactly one. Finally, it splits the 160-bit measurement payload into eight 20-bit channel values.

A period strobe closes each acquisition period. Only frames that finished since the previous strobe are used. A link that delivered nothing, or delivered a partial frame, counts as failed for that period. All results update on the clock edge that samples the strobe and are held until the next strobe. The channel-valid output pulses for one cycle.

Frame layout, where word 0 is the first word received and occupies bits 255:224:

| Bits | Content |
|------|---------|
| 255:240 | card identifier |
| 239:224 | frame number |
| 223:64 | channel payload |
| 63:54 | status bits |
| 53:32 | spare |
| 31:0 | CRC field |

Top module: `dual_link_frame_sel`

## Requirements
- R1: A link's frame is valid only if eight words arrived after a start-of-frame word and bits 31:0 equal the CRC-32 of bits 255:32. The CRC uses polynomial 0x04C11DB7 and initial value 0xFFFFFFFF. It processes the data MSB first, with no reflection and no final inversion. Each link's failure shows on its own flag (`crc_err_a`, `crc_err_b`).
- R2: When link A is valid, its copy is forwarded and `use_link_b` is 0, whatever the state of link B.
- R3: When A is invalid and B is valid, B's copy is forwarded and `use_link_b` is 1.
- R4: When neither link is valid, `chan_valid` stays low for that period and `double_fault` is 1. The channel outputs keep their previous values.
- R5: `crc_diff` is 1 when both links delivered a complete frame and their CRC fields differ. It is 0 otherwise.
- R6: `card_id_err` is 1 when a frame is forwarded and its bits 255:240 differ from `cfg_card_id`. It is 0 in a period with no forwarded frame.
- R7: `missing_frame` is 1 when a forwarded frame number (bits 239:224) is not the previous forwarded number plus one, modulo 2^16. The first forwarded frame after reset never raises it.
- R8: `chan_data` carries channel 1 in bits 159:140 and channel 8 in bits 19:0. Channel k is frame bits 223-20(k-1) down to 204-20(k-1).
- R9: `status_err` equals bits 63:54 of the forwarded frame.
- R10: All outputs change only on the edge that samples `period_tick` high, and `chan_valid` is high for that one cycle only. After reset, all outputs are zero.
- R11: A frame with fewer than eight words before the period strobe counts as invalid, even if its partial content would have matched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_card_id | input | 16 | Expected source card identifier |
| a_word | input | 32 | Link A data word |
| a_valid | input | 1 | Link A word strobe |
| a_sof | input | 1 | Link A first word of frame |
| b_word | input | 32 | Link B data word |
| b_valid | input | 1 | Link B word strobe |
| b_sof | input | 1 | Link B first word of frame |
| period_tick | input | 1 | End of acquisition period |
| chan_data | output | 160 | Eight 20-bit channel values, channel 1 in the top bits |
| chan_valid | output | 1 | One-cycle strobe for new channel data |
| use_link_b | output | 1 | Forwarded copy came from link B |
| crc_err_a | output | 1 | Link A frame invalid this period |
| crc_err_b | output | 1 | Link B frame invalid this period |
| double_fault | output | 1 | Both links invalid this period |
| crc_diff | output | 1 | CRC fields of the two links differ |
| card_id_err | output | 1 | Forwarded card identifier mismatch |
| missing_frame | output | 1 | Frame number did not advance by one |
| status_err | output | 10 | Status bits of the forwarded frame |

## Verification
Every result is registered once, on the edge that samples `period_tick`. The bench therefore raises the strobe on a falling edge, lowers it on the next falling edge, and reads every output at that point, one rising edge after the strobe. One more falling edge later, it checks that `chan_valid` has dropped and that the channel data has not moved. Word bursts on the two links finish at least one cycle before the strobe, and link B may trail A by a few cycles. This keeps the period decision independent of the word timing.

// File: rtl/dlfs_pkg.sv
package dlfs_pkg;
   localparam int FRAME_W  = 256;
   localparam int CRC_W    = 32;
   localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
   localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

   // field positions inside the frame (word 0 on top)
   localparam int ID_LSB   = 240;
   localparam int NUM_LSB  = 224;
   localparam int DATA_LSB = 64;
   localparam int STAT_LSB = 54;

   typedef struct packed {
      logic [15:0]  card_id;
      logic [15:0]  number;
      logic [159:0] payload;
      logic [9:0]   status;
      logic [31:0]  crc;
   } frame_fields_t;

   function automatic logic [31:0] crc_step(input logic [31:0] crc_in,
                                            input logic [31:0] word);
      logic [31:0] c;
      c = crc_in;
      for (int i = 31; i >= 0; i--) begin
         if (c[31] ^ word[i]) c = {c[30:0], 1'b0} ^ CRC_POLY;
         else                 c = {c[30:0], 1'b0};
      end
      return c;
   endfunction
endpackage

// File: rtl/dlfs_link_rx.sv
module dlfs_link_rx
   import dlfs_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int WORDS  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] word,
   input  logic              wvalid,
   input  logic              sof,
   input  logic              tick,
   output frame_fields_t     fields,
   output logic              done,
   output logic              crc_ok
);
   localparam int CNT_W = $clog2(WORDS + 1);
   localparam int LAST  = WORDS - 1;

   logic [CNT_W-1:0]   cnt;
   logic [CRC_W-1:0]   crc_acc;
   logic [FRAME_W-1:0] shreg;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt     <= '0;
         crc_acc <= CRC_SEED;
         shreg   <= '0;
         done    <= 1'b0;
         crc_ok  <= 1'b0;
      end else begin
         if (tick) done <= 1'b0;
         if (wvalid) begin
            if (sof) begin
               cnt     <= CNT_W'(1);
               crc_acc <= crc_step(CRC_SEED, word);
               shreg   <= {shreg[FRAME_W-WORD_W-1:0], word};
               done    <= 1'b0;
            end else if (cnt != '0 && cnt < CNT_W'(WORDS)) begin
               cnt   <= cnt + CNT_W'(1);
               shreg <= {shreg[FRAME_W-WORD_W-1:0], word};
               if (cnt < CNT_W'(LAST)) begin
                  crc_acc <= crc_step(crc_acc, word);
               end else begin
                  done   <= 1'b1;
                  crc_ok <= (crc_acc == word);
               end
            end
         end
      end
   end

   assign fields.card_id = shreg[ID_LSB +: 16];
   assign fields.number  = shreg[NUM_LSB +: 16];
   assign fields.payload = shreg[DATA_LSB +: 160];
   assign fields.status  = shreg[STAT_LSB +: 10];
   assign fields.crc     = shreg[CRC_W-1:0];
endmodule

// File: rtl/dlfs_select.sv
module dlfs_select
   import dlfs_pkg::*;
#(
   parameter int ID_W  = 16,
   parameter int SEQ_W = 16
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            tick,
   input  logic [ID_W-1:0] cfg_id,
   input  frame_fields_t   fa,
   input  logic            done_a,
   input  logic            ok_a,
   input  frame_fields_t   fb,
   input  logic            done_b,
   input  logic            ok_b,
   output logic [159:0]    payload_q,
   output logic            valid_q,
   output logic            sel_b_q,
   output logic            err_a_q,
   output logic            err_b_q,
   output logic            both_q,
   output logic            diff_q,
   output logic            id_err_q,
   output logic            seq_err_q,
   output logic [9:0]      status_q
);
   logic          good_a, good_b, use_any;
   frame_fields_t pick;
   logic [SEQ_W-1:0] last_num;
   logic             have_num;

   assign good_a  = done_a & ok_a;
   assign good_b  = done_b & ok_b;
   assign use_any = good_a | good_b;
   assign pick    = good_a ? fa : fb;

   always_ff @(posedge clk) begin
      if (rst) begin
         payload_q <= '0; valid_q  <= 1'b0; sel_b_q   <= 1'b0;
         err_a_q   <= 1'b0; err_b_q <= 1'b0; both_q    <= 1'b0;
         diff_q    <= 1'b0; id_err_q <= 1'b0; seq_err_q <= 1'b0;
         status_q  <= '0; last_num <= '0; have_num  <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (tick) begin
            valid_q <= use_any;
            sel_b_q <= ~good_a & good_b;
            err_a_q <= ~good_a;
            err_b_q <= ~good_b;
            both_q  <= ~use_any;
            diff_q  <= done_a & done_b & (fa.crc != fb.crc);
            if (use_any) begin
               payload_q <= pick.payload;
               status_q  <= pick.status;
               id_err_q  <= (pick.card_id != cfg_id);
               seq_err_q <= have_num & (pick.number != last_num + SEQ_W'(1));
               last_num  <= pick.number;
               have_num  <= 1'b1;
            end else begin
               id_err_q  <= 1'b0;
               seq_err_q <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/dual_link_frame_sel.sv
module dual_link_frame_sel
   import dlfs_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int WORDS   = 8,
   parameter int CH_N    = 8,
   parameter int CH_W    = 20,
   parameter int ID_W    = 16,
   parameter int SEQ_W   = 16,
   parameter int STAT_W  = 10
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [ID_W-1:0]      cfg_card_id,
   input  logic [WORD_W-1:0]    a_word,
   input  logic                 a_valid,
   input  logic                 a_sof,
   input  logic [WORD_W-1:0]    b_word,
   input  logic                 b_valid,
   input  logic                 b_sof,
   input  logic                 period_tick,
   output logic [CH_N*CH_W-1:0] chan_data,
   output logic                 chan_valid,
   output logic                 use_link_b,
   output logic                 crc_err_a,
   output logic                 crc_err_b,
   output logic                 double_fault,
   output logic                 crc_diff,
   output logic                 card_id_err,
   output logic                 missing_frame,
   output logic [STAT_W-1:0]    status_err
);
   localparam int PAY_W = CH_N * CH_W;
   localparam int LINKS = 2;

   if (WORD_W * WORDS != FRAME_W) begin : g_bad_frame
      $error("frame must be %0d bits", FRAME_W);
   end
   if (PAY_W != 160 || ID_W != 16 || SEQ_W != 16 || STAT_W != 10) begin : g_bad_fields
      $error("field widths do not match the frame layout");
   end

   logic [WORD_W-1:0] lw   [LINKS];
   logic              lv   [LINKS];
   logic              ls   [LINKS];
   frame_fields_t     lf   [LINKS];
   logic              ldn  [LINKS];
   logic              lok  [LINKS];

   assign lw[0] = a_word; assign lv[0] = a_valid; assign ls[0] = a_sof;
   assign lw[1] = b_word; assign lv[1] = b_valid; assign ls[1] = b_sof;

   for (genvar l = 0; l < LINKS; l++) begin : g_link
      dlfs_link_rx #(.WORD_W(WORD_W), .WORDS(WORDS)) u_rx (
         .clk(clk), .rst(rst), .word(lw[l]), .wvalid(lv[l]), .sof(ls[l]),
         .tick(period_tick), .fields(lf[l]), .done(ldn[l]), .crc_ok(lok[l]));
   end

   logic [PAY_W-1:0] payload;

   dlfs_select #(.ID_W(ID_W), .SEQ_W(SEQ_W)) u_sel (
      .clk(clk), .rst(rst), .tick(period_tick), .cfg_id(cfg_card_id),
      .fa(lf[0]), .done_a(ldn[0]), .ok_a(lok[0]),
      .fb(lf[1]), .done_b(ldn[1]), .ok_b(lok[1]),
      .payload_q(payload), .valid_q(chan_valid), .sel_b_q(use_link_b),
      .err_a_q(crc_err_a), .err_b_q(crc_err_b), .both_q(double_fault),
      .diff_q(crc_diff), .id_err_q(card_id_err), .seq_err_q(missing_frame),
      .status_q(status_err));

   // channel k (0-based) taken from the top of the payload downward
   for (genvar k = 0; k < CH_N; k++) begin : g_chan
      assign chan_data[PAY_W-1-k*CH_W -: CH_W] = payload[PAY_W-1-k*CH_W -: CH_W];
   end
endmodule

// File: rtl/dlfs_chk.sv
module dlfs_chk (
   input logic         clk,
   input logic         rst,
   input logic         period_tick,
   input logic [159:0] chan_data,
   input logic         chan_valid,
   input logic         use_link_b,
   input logic         crc_err_a,
   input logic         double_fault
);
   assert_prefer_a_R2: assert property (@(posedge clk) disable iff (rst)
      (chan_valid && !crc_err_a) |-> !use_link_b);
   assert_b_only_if_a_bad_R3: assert property (@(posedge clk) disable iff (rst)
      use_link_b |-> crc_err_a);
   assert_double_no_valid_R4: assert property (@(posedge clk) disable iff (rst)
      double_fault |-> (!chan_valid && !use_link_b));
   assert_valid_after_tick_R10: assert property (@(posedge clk) disable iff (rst)
      chan_valid |-> $past(period_tick));
   assert_hold_between_ticks_R10: assert property (@(posedge clk) disable iff (rst)
      !$past(period_tick) |-> ($stable(chan_data) && $stable(double_fault)));
endmodule

bind dual_link_frame_sel dlfs_chk u_chk (
   .clk(clk), .rst(rst), .period_tick(period_tick), .chan_data(chan_data),
   .chan_valid(chan_valid), .use_link_b(use_link_b), .crc_err_a(crc_err_a),
   .double_fault(double_fault));

// File: tb/dual_link_frame_sel_test.sv
module dual_link_frame_sel_test;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [15:0] cfg_card_id = 16'hC0DE;
   logic [31:0] a_word = '0, b_word = '0;
   logic a_valid = 0, a_sof = 0, b_valid = 0, b_sof = 0, period_tick = 0;
   logic [159:0] chan_data;
   logic chan_valid, use_link_b, crc_err_a, crc_err_b, double_fault;
   logic crc_diff, card_id_err, missing_frame;
   logic [9:0] status_err;

   int total = 0, bad = 0, cyc = 0;
   logic [15:0]  exp_last = '0;
   logic         exp_have = 1'b0;
   logic [159:0] exp_data = '0;
   logic [9:0]   exp_stat = '0;

   always #10 clk = ~clk;

   dual_link_frame_sel uut (.*);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         bad = bad + 1; total = total + 1;
         $display("FAIL watchdog: run hung, actual=%0d expected<150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic logic [31:0] ref_crc(input logic [255:0] f);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 255; i >= 32; i--) begin
         logic fb = c[31] ^ f[i];
         c = {c[30:0], 1'b0};
         if (fb) c = c ^ 32'h04C1_1DB7;
      end
      return c;
   endfunction

   function automatic logic [255:0] mk(input logic [15:0] id, input logic [15:0] num,
                                       input logic [159:0] pay, input logic [9:0] st,
                                       input logic [21:0] spare);
      logic [255:0] f = {id, num, pay, st, spare, 32'h0};
      f[31:0] = ref_crc(f);
      return f;
   endfunction

   task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // na/nb: words sent per link (8 = full frame); lag delays link B
   task automatic period(input logic [255:0] fa, input logic [255:0] fb,
                         input int na, input int nb, input int lag);
      logic ga, gb, use_any;
      logic [255:0] p;
      logic [159:0] prev;
      for (int t = 0; t < 8 + lag; t++) begin
         @(negedge clk);
         a_valid = (t < na); a_sof = (t == 0) && (na > 0);
         a_word  = (t < 8) ? fa[255 - 32*t -: 32] : '0;
         b_valid = (t >= lag) && (t - lag < nb); b_sof = (t == lag) && (nb > 0);
         b_word  = (t >= lag && t - lag < 8) ? fb[255 - 32*(t-lag) -: 32] : '0;
      end
      @(negedge clk);
      a_valid = 0; a_sof = 0; b_valid = 0; b_sof = 0;
      @(negedge clk); period_tick = 1;
      @(negedge clk); period_tick = 0;
      ga = (na == 8) && (ref_crc(fa) == fa[31:0]);
      gb = (nb == 8) && (ref_crc(fb) == fb[31:0]);
      use_any = ga | gb;
      p = ga ? fa : fb;
      chk("R1 crc_err_a", 160'(crc_err_a), 160'(!ga));
      chk("R1 crc_err_b", 160'(crc_err_b), 160'(!gb));
      chk("R2/R3 use_link_b", 160'(use_link_b), 160'(!ga && gb));
      chk("R4 chan_valid", 160'(chan_valid), 160'(use_any));
      chk("R4 double_fault", 160'(double_fault), 160'(!use_any));
      chk("R5 crc_diff", 160'(crc_diff), 160'((na == 8) && (nb == 8) && (fa[31:0] != fb[31:0])));
      if (use_any) begin
         chk("R6 card_id_err", 160'(card_id_err), 160'(p[255:240] != cfg_card_id));
         chk("R7 missing_frame", 160'(missing_frame),
             160'(exp_have && (p[239:224] != exp_last + 16'd1)));
         exp_last = p[239:224]; exp_have = 1'b1;
         exp_data = p[223:64]; exp_stat = p[63:54];
      end else begin
         chk("R6 card_id_err idle", 160'(card_id_err), 160'(0));
         chk("R7 missing_frame idle", 160'(missing_frame), 160'(0));
      end
      chk("R8 chan_data", chan_data, exp_data);
      chk("R8 channel 1 top", 160'(chan_data[159:140]), 160'(exp_data[159:140]));
      chk("R9 status_err", 160'(status_err), 160'(exp_stat));
      prev = chan_data;
      @(negedge clk);
      chk("R10 valid pulse", 160'(chan_valid), 160'(0));
      chk("R10 data held", chan_data, prev);
   endtask

   function automatic logic [159:0] rpay();
      return {$urandom, $urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      logic [255:0] fa, fb;
      logic [15:0] n;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      chk("R10 reset chan_data", chan_data, '0);
      chk("R10 reset flags", 160'({chan_valid, use_link_b, crc_err_a, crc_err_b, double_fault,
          crc_diff, card_id_err, missing_frame, status_err}), 160'(0));

      n = 16'h0100;
      // first frame after reset with an arbitrary number: no missing-frame error (R7)
      fa = mk(cfg_card_id, n, rpay(), 10'h2A5, 22'h0); period(fa, fa, 8, 8, 0);
      // R3: A corrupted, B good
      n++; fb = mk(cfg_card_id, n, rpay(), 10'h011, 22'h0); fa = fb; fa[100] ^= 1'b1;
      period(fa, fb, 8, 8, 2);
      // R2: A good, B corrupted
      n++; fa = mk(cfg_card_id, n, rpay(), 10'h3FF, 22'h0); fb = fa; fb[5] ^= 1'b1;
      period(fa, fb, 8, 8, 1);
      // R4: both bad
      n++; fa = mk(cfg_card_id, n, rpay(), 10'h1, 22'h0); fb = fa; fa[200] ^= 1; fb[201] ^= 1;
      period(fa, fb, 8, 8, 0);
      // R7: gap left by the lost frame is reported
      n++; fa = mk(cfg_card_id, n, rpay(), 10'h2, 22'h0); period(fa, fa, 8, 8, 0);
      // R5: both valid with different spare bits -> different CRC, A still chosen
      n++; fa = mk(cfg_card_id, n, rpay(), 10'h3, 22'h1); fb = fa; fb[53:32] = 22'h2;
      fb[31:0] = ref_crc(fb); period(fa, fb, 8, 8, 3);
      // R6: wrong card id
      n++; fa = mk(16'hBEEF, n, rpay(), 10'h4, 22'h0); period(fa, fa, 8, 8, 0);
      // R7: number wraps from FFFF to 0 without error
      n = 16'hFFFF; fa = mk(cfg_card_id, n, rpay(), 10'h5, 22'h0); period(fa, fa, 8, 8, 0);
      n = 16'h0000; fa = mk(cfg_card_id, n, rpay(), 10'h6, 22'h0); period(fa, fa, 8, 8, 0);
      // R11: A truncated, B full
      n++; fa = mk(cfg_card_id, n, rpay(), 10'h7, 22'h0); period(fa, fa, 5, 8, 0);
      // R11: both truncated, nothing arrives
      n++; period(fa, fa, 7, 0, 0);

      // random periods
      for (int i = 0; i < 60; i++) begin
         int na, nb;
         logic [15:0] id;
         n = n + (($urandom % 10 == 0) ? 16'd2 : 16'd1);
         id = ($urandom % 10 == 0) ? ~cfg_card_id : cfg_card_id;
         fa = mk(id, n, rpay(), 10'($urandom), 22'($urandom));
         fb = ($urandom % 8 == 0) ? mk(id, n, rpay(), 10'($urandom), 22'($urandom)) : fa;
         if ($urandom % 5 == 0) fa[$urandom % 256] ^= 1'b1;
         if ($urandom % 5 == 0) fb[$urandom % 256] ^= 1'b1;
         na = ($urandom % 10 == 0) ? int'($urandom % 8) : 8;
         nb = ($urandom % 10 == 0) ? int'($urandom % 8) : 8;
         period(fa, fb, na, nb, int'($urandom % 4));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule